// File: doc/BRIEF.md
# Two-Source Masked Interrupt Controller

This block collects two interrupt sources for a small processor core: a one-cycle underflow pulse from a down-counting timer, and a rising edge on an external interrupt pin. Each event sets a sticky bit in a flag register. The bit is set whatever the mask says, so software can poll for events that it has chosen not to take as interrupts.

A mask register holds one enable bit per source and a global enable in its top bit. The block issues a one-cycle request to the core when the global enable is set and at least one flagged source is enabled. Every source uses the same vector address, 0x3FE, so the service routine reads the flag register to find the cause. On entry the block clears the global enable by itself, which blocks nesting. A return-from-interrupt strobe sets the global enable again. Only a software write clears a flag. A flag that is still set when the routine returns therefore raises a new request.

The external source counts only while the pin is switched to its interrupt function. The pin input is taken as already synchronous to the clock.

Top module: `irq_ctrl2`

## Requirements
- R1: After reset the mask register and the flag register both read 0x00, and the request output is low.
- R2: A timer underflow pulse sets flag bit 0 one clock later, whatever the mask register holds. The bit then stays set until software writes it.
- R3: A low-to-high change of the pin sets flag bit 1 one clock later, but only while the pin-function enable is 1. A falling edge, a pin held high, or any edge while the enable is 0 leaves bit 1 unchanged.
- R4: The request output pulses high for one cycle in the clock after the mask register holds global enable bit 7 = 1 together with a source enable (bit 1 for the pin, bit 0 for the timer) whose flag bit is set. With any other combination it stays low.
- R5: On the same edge that raises the request, global enable bit 7 is cleared. The request then lasts exactly one cycle.
- R6: A return-from-interrupt strobe sets global enable bit 7 at the next edge. If it arrives together with a mask write, bit 7 still ends up set.
- R7: A flag left set when the global enable comes back raises the request again, one cycle after the global enable is set.
- R8: A flag write replaces flag bits 1:0. When a source event and a write of 0 to the same flag arrive in the same cycle, the flag ends up set.
- R9: Mask bits 6:2 and flag bits 7:2 always read 0, whatever value is written.
- R10: The vector address output always reads 0x3FE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_uflow_i | input | 1 | Timer underflow pulse, one cycle |
| ext_pin_i | input | 1 | External interrupt pin level, synchronous |
| ext_fn_en_i | input | 1 | Pin works as interrupt input when 1 |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask register write data |
| flag_we_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 8 | Flag register write data |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mask_o | output | 8 | Mask register read value |
| flags_o | output | 8 | Flag register read value |
| irq_o | output | 1 | Interrupt request pulse to the core |
| vec_o | output | 10 | Shared interrupt vector address |

## Verification
The bench builds the block with its default parameters: 8-bit registers, two sources and a 10-bit vector. With only three mask bits and two flag bits that matter, it can walk every combination of global enable, source enables and pending flags, 32 cases in all, and work out the expected request and the state of the global enable after entry for each one. The same small configuration lets directed sequences reach the collisions between an event and a clear, and between a return strobe and a mask write. It also covers pin edges with the pin function switched on and switched off.

// File: rtl/irq_ctrl2_pkg.sv
package irq_ctrl2_pkg;
  localparam int unsigned IRQ_DATA_W  = 8;
  localparam int unsigned IRQ_N_SRC   = 2;
  localparam int unsigned IRQ_VEC_W   = 10;
  localparam logic [IRQ_VEC_W-1:0] IRQ_VEC_ADDR = 10'h3FE;

  typedef enum int unsigned {
    SRC_TMR = 0,
    SRC_EXT = 1
  } irq_src_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic arm_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LEVEL;
    else        prev_q <= pin_i;
  end

  assign rise_o = arm_i & pin_i & ~prev_q;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SRC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  evt_i,
  output logic [N_SRC-1:0]  flags_o
);
  function automatic logic flag_next(input logic cur, input logic we,
                                     input logic wbit, input logic evt);
    return (we ? wbit : cur) | evt;
  endfunction

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= flag_next(q, we_i, wdata_i[g], evt_i[g]);
    end
    assign flags_o[g] = q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned N_SRC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              reti_i,
  input  logic              entry_i,
  output logic              gie_o,
  output logic [N_SRC-1:0]  en_o
);
  localparam int unsigned GIE_POS = DATA_W - 1;

  // entry clears, then return sets, then software write
  function automatic logic gie_next(input logic cur, input logic entry,
                                    input logic reti, input logic we,
                                    input logic wbit);
    if (entry)     return 1'b0;
    else if (reti) return 1'b1;
    else if (we)   return wbit;
    return cur;
  endfunction

  logic             gie_q;
  logic [N_SRC-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gie_q <= gie_next(gie_q, entry_i, reti_i, we_i, wdata_i[GIE_POS]);
      if (we_i) en_q <= wdata_i[N_SRC-1:0];
    end
  end

  assign gie_o = gie_q;
  assign en_o  = en_q;
endmodule

// File: rtl/irq_ctrl2.sv
module irq_ctrl2
  import irq_ctrl2_pkg::*;
#(
  parameter int unsigned DATA_W = IRQ_DATA_W,
  parameter int unsigned N_SRC  = IRQ_N_SRC,
  parameter int unsigned VEC_W  = IRQ_VEC_W,
  parameter logic [VEC_W-1:0] VEC_ADDR = IRQ_VEC_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_uflow_i,
  input  logic              ext_pin_i,
  input  logic              ext_fn_en_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  input  logic              flag_we_i,
  input  logic [DATA_W-1:0] flag_wdata_i,
  input  logic              reti_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] flags_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam int unsigned GIE_POS = DATA_W - 1;

  function automatic logic want_irq(input logic gie,
                                    input logic [N_SRC-1:0] fl,
                                    input logic [N_SRC-1:0] en);
    return gie & (|(fl & en));
  endfunction

  logic             ext_rise;
  logic             entry_fire;
  logic             gie;
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] flag_q;
  logic [N_SRC-1:0] evt;
  logic             irq_q;

  irq_edge_det #(.IDLE_LEVEL(1'b1)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .arm_i  (ext_fn_en_i),
    .rise_o (ext_rise)
  );

  always_comb begin
    evt = '0;
    evt[SRC_TMR] = tmr_uflow_i;
    evt[SRC_EXT] = ext_rise;
  end

  irq_flag_reg #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (flag_we_i),
    .wdata_i (flag_wdata_i),
    .evt_i   (evt),
    .flags_o (flag_q)
  );

  assign entry_fire = want_irq(gie, flag_q, src_en);

  irq_mask_reg #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .reti_i  (reti_i),
    .entry_i (entry_fire),
    .gie_o   (gie),
    .en_o    (src_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= entry_fire;
  end

  always_comb begin
    mask_o  = '0;
    flags_o = '0;
    mask_o[GIE_POS]    = gie;
    mask_o[N_SRC-1:0]  = src_en;
    flags_o[N_SRC-1:0] = flag_q;
  end

  assign irq_o = irq_q;
  assign vec_o = VEC_ADDR;
endmodule

// File: rtl/irq_ctrl2_chk.sv
module irq_ctrl2_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VEC_W  = 10,
  parameter logic [VEC_W-1:0] VEC_ADDR = 10'h3FE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_uflow_i,
  input logic              flag_we_i,
  input logic              reti_i,
  input logic              ext_rise,
  input logic              entry_fire,
  input logic [DATA_W-1:0] mask_o,
  input logic [DATA_W-1:0] flags_o,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o
);
  localparam int unsigned G = DATA_W - 1;

  p_tmr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_uflow_i |=> flags_o[0]);
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !flag_we_i) |=> flags_o[0]);
  p_ext_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> flags_o[1]);
  p_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o[G] && |(flags_o[1:0] & mask_o[1:0])) |=> irq_o);
  p_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_o[G] |=> !irq_o);
  p_entry_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mask_o[G]);
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  p_reti_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !entry_fire) |=> mask_o[G]);
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o[G-1:2] == '0) && (flags_o[DATA_W-1:2] == '0));
  p_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o == VEC_ADDR);
endmodule

bind irq_ctrl2 irq_ctrl2_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tmr_uflow_i (tmr_uflow_i),
  .flag_we_i   (flag_we_i),
  .reti_i      (reti_i),
  .ext_rise    (ext_rise),
  .entry_fire  (entry_fire),
  .mask_o      (mask_o),
  .flags_o     (flags_o),
  .irq_o       (irq_o),
  .vec_o       (vec_o)
);

// File: tb/irq_ctrl2_bench.sv
`timescale 1ns/1ps
module irq_ctrl2_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_uflow_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       ext_fn_en_i = 1'b0;
  logic       mask_we_i = 1'b0;
  logic [7:0] mask_wdata_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] flag_wdata_i = '0;
  logic       reti_i = 1'b0;
  logic [7:0] mask_o;
  logic [7:0] flags_o;
  logic       irq_o;
  logic [9:0] vec_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl2 u_irq_ctrl2 (
    .clk(clk), .rst_n(rst_n), .tmr_uflow_i(tmr_uflow_i), .ext_pin_i(ext_pin_i),
    .ext_fn_en_i(ext_fn_en_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i), .reti_i(reti_i),
    .mask_o(mask_o), .flags_o(flags_o), .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] v);
    @(negedge clk); mask_we_i = 1'b1; mask_wdata_i = v;
    @(negedge clk); mask_we_i = 1'b0;
  endtask

  task automatic wr_flag(input logic [7:0] v);
    @(negedge clk); flag_we_i = 1'b1; flag_wdata_i = v;
    @(negedge clk); flag_we_i = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 flags", flags_o, 8'h00);
    chk("R1 irq", irq_o, 1'b0);
    chk("R10 vector", vec_o, 10'h3FE);

    // R2 timer pulse latches with everything masked
    @(negedge clk); tmr_uflow_i = 1'b1;
    @(negedge clk); tmr_uflow_i = 1'b0;
    chk("R2 tmr flag", flags_o, 8'h01);
    step(3);
    chk("R2 sticky", flags_o, 8'h01);
    chk("R2 no irq while masked", irq_o, 1'b0);
    wr_flag(8'h00);
    chk("R8 write clears", flags_o, 8'h00);

    // R3 pin edges
    @(negedge clk); ext_pin_i = 1'b1;
    step(2);
    chk("R3 fn disabled edge ignored", flags_o[1], 1'b0);
    ext_pin_i = 1'b0; step(1);
    ext_fn_en_i = 1'b1; step(1);
    ext_pin_i = 1'b1; step(1);
    chk("R3 rising edge", flags_o[1], 1'b1);
    wr_flag(8'h00);
    step(2);
    chk("R3 held high no refire", flags_o[1], 1'b0);
    ext_pin_i = 1'b0; step(2);
    chk("R3 falling edge ignored", flags_o[1], 1'b0);
    ext_pin_i = 1'b1; step(1);
    chk("R3 second rising edge", flags_o, 8'h02);
    ext_pin_i = 1'b0;
    wr_flag(8'h00);

    // R4 exhaustive sweep: gie/ext_en/tmr_en x flags
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 4; f++) begin
        logic [7:0] enc;
        logic exp_irq;
        enc = {m[2], 5'b0, m[1:0]};
        exp_irq = m[2] && ((f[1:0] & m[1:0]) != 2'b00);
        wr_mask(8'h00);
        wr_flag(f[7:0]);
        wr_mask(enc);
        step(1);
        chk($sformatf("R4 irq m=%0d f=%0d", m, f), irq_o, exp_irq);
        chk($sformatf("R5 gie m=%0d f=%0d", m, f), mask_o[7], m[2] && !exp_irq);
        step(1);
        chk($sformatf("R5 one cycle m=%0d f=%0d", m, f), irq_o, 1'b0);
        chk("R9 mask unused", mask_o[6:2], 5'b0);
      end
    end

    // R7 re-request after return with flag still set
    wr_mask(8'h00);
    wr_flag(8'h01);
    wr_mask(8'h81);
    step(1);
    chk("R7 first request", irq_o, 1'b1);
    step(2);
    @(negedge clk); reti_i = 1'b1;
    @(negedge clk); reti_i = 1'b0;
    chk("R6 reti sets gie", mask_o[7], 1'b1);
    step(1);
    chk("R7 request again", irq_o, 1'b1);
    chk("R7 gie cleared", mask_o[7], 1'b0);

    // R6 reti wins over mask write of gie=0
    wr_mask(8'h00);
    wr_flag(8'h00);
    @(negedge clk); reti_i = 1'b1; mask_we_i = 1'b1; mask_wdata_i = 8'h02;
    @(negedge clk); reti_i = 1'b0; mask_we_i = 1'b0;
    chk("R6 reti beats write", mask_o, 8'h82);
    wr_mask(8'h00);

    // R8 event beats clear in same cycle
    wr_flag(8'h01);
    @(negedge clk); flag_we_i = 1'b1; flag_wdata_i = 8'h00; tmr_uflow_i = 1'b1;
    @(negedge clk); flag_we_i = 1'b0; tmr_uflow_i = 1'b0;
    chk("R8 event wins", flags_o[0], 1'b1);
    wr_flag(8'h02);
    chk("R8 write sets bit1", flags_o, 8'h02);

    // R9 unused bits
    wr_flag(8'hFC);
    chk("R9 flag unused", flags_o, 8'h00);
    wr_mask(8'h7C);
    chk("R9 mask unused", mask_o, 8'h00);
    chk("R10 vector end", vec_o, 10'h3FE);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule